// File: doc/BRIEF.md
# Two-Wire Write-Only DAC Code Register Slave

This block sits behind a pair of DAC channels and takes their 8-bit output codes from a two-wire serial bus. It samples the bus clock and data lines with the system clock and finds the bus START and STOP conditions in the sampled signals. It then tracks the nine-clock byte framing and answers one 7-bit slave address. Two of the address bits come from strap inputs, so up to four of these slaves can share one bus.

After an address that matches and carries the write flag, the master sends any number of two-byte pairs. Each pair is a command byte followed by a data byte. The command byte picks the channel, or asks for all channels to be cleared. The data byte is loaded into the chosen register when its acknowledge clock ends. The slave acknowledges every byte it accepts by enabling an open-drain pull-down on the data line. Reads and clock stretching are not supported.

Top module: `dac_bus_slave`

## Requirements
- R1: After reset every channel register reads 0 and the SDA pull-down enable is low.
- R2: SDA falling while SCL is high (START) opens an address phase. This holds from idle and also in the middle of a transfer (a repeated START), where the pending byte is dropped.
- R3: The address byte is sent MSB first as 0,1,0,1,1,AD1,AD0,RW. AD1 and AD0 are the strap inputs `addr_sel_i[1]` and `addr_sel_i[0]`. The slave acknowledges only when all seven address bits match and RW is 0. Any other address byte gets no acknowledge, and the slave then ignores the bus until the next START.
- R4: The pull-down enable rises only after the SCL fall that ends the eighth bit of an accepted byte. It drops at the SCL fall that ends the ninth (acknowledge) clock. It never changes while the sampled SCL is high.
- R5: Data bits are taken MSB first on SCL rising edges.
- R6: Command bit 0 selects channel 0 or 1. The data byte that follows is written to that channel at the end of its acknowledge clock. Every command and data byte is acknowledged.
- R7: A command with bit 3 set clears every channel register to 0 when the following data byte completes. The data value is discarded.
- R8: Command bits 7..4, 2 and 1 have no effect.
- R9: One transaction may carry several command/data pairs, and each pair updates its own channel.
- R10: SDA rising while SCL is high (STOP) returns the slave to idle with SDA released. A command byte left without its data byte changes no register.
- R11: A transfer that was not acknowledged leaves every register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_sel_i | input | 2 | Strap inputs for the two low address bits (bit 1 = AD1) |
| sda_pull_o | output | 1 | Enable for the open-drain pull-down on SDA |
| ch_code_o | output | 16 | Channel registers, channel 0 in bits 7..0 |

## Verification
The assertions assume that SDA changes while SCL is high only as a START or a STOP. They also assume each SCL level lasts long enough that the two-flop sampling sees every edge, and that the strap inputs stay fixed during a transfer. The bench drives a bus master with a quarter-period of ten system clocks. It moves SDA only in the middle of the SCL low phase, except inside its START and STOP routines, and it sets the straps only while the bus is idle. The data line the design sees is the wired-AND of the master's drive and the slave's pull-down.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADDR = 3'd1,
    ST_CMD  = 3'd2,
    ST_DATA = 3'd3,
    ST_SKIP = 3'd4
  } phase_e;

  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/dbs_sync.sv
module dbs_sync #(
  parameter int         W       = 2,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [W-1:0] q;
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST_VAL;
        else        q <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST_VAL;
        else        q <= g_stage[g-1].q;
      end
    end
  end

  assign q_o = g_stage[STAGES-1].q;
endmodule

// File: rtl/dbs_bus_events.sv
module dbs_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_prev, sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_prev <= scl_s;
      sda_prev <= sda_s;
    end
  end

  always_comb begin
    scl_rise  = scl_s & ~scl_prev;
    scl_fall  = ~scl_s & scl_prev;
    start_det = scl_s & scl_prev & sda_prev & ~sda_s;
    stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;
  end
endmodule

// File: rtl/dbs_reg_bank.sv
module dbs_reg_bank #(
  parameter int NUM_CH = 2,
  parameter int DATA_W = 8,
  parameter int SEL_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic                     clr_en,
  input  logic [SEL_W-1:0]         sel,
  input  logic [DATA_W-1:0]        wdata,
  output logic [NUM_CH*DATA_W-1:0] regs_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [DATA_W-1:0] code_q, code_d;
    logic              code_en;

    always_comb begin
      code_en = clr_en | (wr_en & (sel == SEL_W'(c)));
      code_d  = clr_en ? '0 : wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       code_q <= '0;
      else if (code_en) code_q <= code_d;
    end

    assign regs_o[c*DATA_W +: DATA_W] = code_q;
  end
endmodule

// File: rtl/dac_bus_slave.sv
module dac_bus_slave #(
  parameter int         DATA_W     = 8,
  parameter int         NUM_CH     = 2,
  parameter int         PIN_W      = 2,
  parameter logic [4:0] ADDR_FIXED = 5'b01011,
  parameter int         CLR_BIT    = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     scl_i,
  input  logic                     sda_i,
  input  logic [PIN_W-1:0]         addr_sel_i,
  output logic                     sda_pull_o,
  output logic [NUM_CH*DATA_W-1:0] ch_code_o
);
  import dbs_pkg::*;

  localparam int SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int ADDR_W = $bits(ADDR_FIXED) + PIN_W;
  localparam int CNT_W = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(DATA_W + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_ni_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni_q = rst_pipe[1];

  // line sampling and bus events
  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start_det, stop_det;

  dbs_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk   (clk),
    .rst_n (rst_ni_q),
    .d_i   ({scl_i, sda_i}),
    .q_o   ({scl_s, sda_s})
  );

  dbs_bus_events u_events (
    .clk       (clk),
    .rst_n     (rst_ni_q),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  // byte framing state
  phase_e              phase_q, phase_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [DATA_W-1:0]   shift_q, shift_d;
  logic                shift_en;
  logic                pull_q, pull_d;
  logic [SEL_W-1:0]    sel_q, sel_d;
  logic                clr_q, clr_d;
  logic                cmd_en;
  logic                ack_end, commit_pair;
  logic                addr_hit, in_byte;

  always_comb begin
    addr_hit = (shift_q[DATA_W-1 -: ADDR_W] == {ADDR_FIXED, addr_sel_i}) &&
               !shift_q[0];
    in_byte  = (phase_q == ST_ADDR) || (phase_q == ST_CMD) ||
               (phase_q == ST_DATA);
  end

  always_comb begin
    phase_d     = phase_q;
    cnt_d       = cnt_q;
    shift_d     = shift_q;
    shift_en    = 1'b0;
    pull_d      = pull_q;
    sel_d       = sel_q;
    clr_d       = clr_q;
    cmd_en      = 1'b0;
    ack_end     = 1'b0;
    commit_pair = 1'b0;
    if (start_det) begin
      phase_d = ST_ADDR;
      cnt_d   = '0;
      pull_d  = 1'b0;
    end else if (stop_det) begin
      phase_d = ST_IDLE;
      cnt_d   = '0;
      pull_d  = 1'b0;
    end else if (in_byte) begin
      if (scl_rise) begin
        if (cnt_q < LAST_BIT) begin
          shift_d  = {shift_q[DATA_W-2:0], sda_s};
          shift_en = 1'b1;
          cnt_d    = cnt_q + 1'b1;
        end else if (cnt_q == LAST_BIT) begin
          cnt_d = ACK_BIT;
        end
      end else if (scl_fall) begin
        if (cnt_q == LAST_BIT) begin
          if ((phase_q == ST_ADDR) && !addr_hit) begin
            phase_d = ST_SKIP;
            cnt_d   = '0;
          end else begin
            pull_d = 1'b1;
          end
        end else if (cnt_q == ACK_BIT) begin
          pull_d  = 1'b0;
          cnt_d   = '0;
          ack_end = 1'b1;
          unique case (phase_q)
            ST_ADDR: phase_d = ST_CMD;
            ST_CMD: begin
              phase_d = ST_DATA;
              cmd_en  = 1'b1;
              sel_d   = shift_q[SEL_W-1:0];
              clr_d   = shift_q[CLR_BIT];
            end
            default: begin
              phase_d     = ST_CMD;
              commit_pair = 1'b1;
            end
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni_q) begin
    if (!rst_ni_q) begin
      phase_q <= ST_IDLE;
      cnt_q   <= '0;
      pull_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      pull_q  <= pull_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni_q) begin
    if (!rst_ni_q)     shift_q <= '0;
    else if (shift_en) shift_q <= shift_d;
  end

  always_ff @(posedge clk or negedge rst_ni_q) begin
    if (!rst_ni_q) begin
      sel_q <= '0;
      clr_q <= 1'b0;
    end else if (cmd_en) begin
      sel_q <= sel_d;
      clr_q <= clr_d;
    end
  end

  dbs_reg_bank #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_bank (
    .clk    (clk),
    .rst_n  (rst_ni_q),
    .wr_en  (commit_pair & ~clr_q),
    .clr_en (commit_pair & clr_q),
    .sel    (sel_q),
    .wdata  (shift_q),
    .regs_o (ch_code_o)
  );

  assign sda_pull_o = pull_q;
endmodule

// File: rtl/dbs_checker.sv
module dbs_checker #(
  parameter int NUM_CH = 2,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     scl_s,
  input logic                     start_det,
  input logic                     stop_det,
  input logic                     commit_pair,
  input dbs_pkg::phase_e          phase_q,
  input logic [CNT_W-1:0]         cnt_q,
  input logic                     sda_pull_o,
  input logic [NUM_CH*DATA_W-1:0] ch_code_o
);
  import dbs_pkg::*;

  p_start_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (phase_q == ST_ADDR) && (cnt_q == '0));

  p_stop_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (phase_q == ST_IDLE) && !sda_pull_o);

  p_pull_scl_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_o) |-> !scl_s);

  p_pull_in_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull_o |-> (cnt_q >= CNT_W'(DATA_W)));

  p_quiet_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_q == ST_IDLE) || (phase_q == ST_SKIP)) |-> !sda_pull_o);

  p_reg_update_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ch_code_o) |-> $past(commit_pair));
endmodule

bind dac_bus_slave dbs_checker #(
  .NUM_CH (NUM_CH),
  .DATA_W (DATA_W),
  .CNT_W  (CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_ni_q),
  .scl_s       (scl_s),
  .start_det   (start_det),
  .stop_det    (stop_det),
  .commit_pair (commit_pair),
  .phase_q     (phase_q),
  .cnt_q       (cnt_q),
  .sda_pull_o  (sda_pull_o),
  .ch_code_o   (ch_code_o)
);

// File: tb/dac_bus_slave_tb.sv
`timescale 1ns/1ps
module dac_bus_slave_tb;
  localparam time Q = 40ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl = 1'b1;
  logic        sda_m = 1'b1;
  logic [1:0]  sel = 2'b10;
  logic        sda_pull;
  logic [15:0] codes;
  logic        sda_bus;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  assign sda_bus = sda_m & ~sda_pull;

  always #2 clk = ~clk;

  dac_bus_slave u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl),
    .sda_i      (sda_bus),
    .addr_sel_i (sel),
    .sda_pull_o (sda_pull),
    .ch_code_o  (codes)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; #Q;
    scl = 1'b1;   #Q;
    sda_m = 1'b0; #Q;
    scl = 1'b0;   #Q;
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; #Q;
    scl = 1'b1;   #Q;
    sda_m = 1'b1; #Q; #Q;
  endtask

  // sends one byte MSB first (R5) and returns whether it was acknowledged
  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      #Q sda_m = b[i];
      #Q scl = 1'b1;
      #Q;
      if (i == 0) chk("R4 no pull during bit 8", {31'd0, sda_pull}, 32'd0);
      scl = 1'b0;
    end
    #Q sda_m = 1'b1;
    #Q scl = 1'b1;
    #Q acked = ~sda_bus;
    scl = 1'b0;
    #Q chk("R4 released after ack clock", {31'd0, sda_pull}, 32'd0);
  endtask

  task automatic write_pair(input logic [7:0] cmd, input logic [7:0] dat, input string req);
    logic a;
    send_byte(cmd, a); chk({req, " cmd ack"}, {31'd0, a}, 32'd1);
    send_byte(dat, a); chk({req, " data ack"}, {31'd0, a}, 32'd1);
  endtask

  task automatic open_addr(input logic [7:0] ab, input logic exp_ack, input string req);
    logic a;
    bus_start();
    send_byte(ab, a);
    chk(req, {31'd0, a}, {31'd0, exp_ack});
  endtask

  task automatic t_reset();
    chk("R1 codes after reset", {16'd0, codes}, 32'd0);
    chk("R1 pull after reset", {31'd0, sda_pull}, 32'd0);
  endtask

  task automatic t_write_ch0();
    open_addr(8'h5C, 1'b1, "R3 address ack");
    write_pair(8'h00, 8'hA5, "R6");
    bus_stop();
    chk("R6 R5 ch0 written", {16'd0, codes}, 32'h0000_00A5);
  endtask

  task automatic t_other_bits();
    open_addr(8'h5C, 1'b1, "R3 address ack");
    write_pair(8'hF1, 8'h3C, "R8");
    bus_stop();
    chk("R8 ch1 with stray bits", {16'd0, codes}, 32'h0000_3CA5);
  endtask

  task automatic t_multi_pair();
    open_addr(8'h5C, 1'b1, "R3 address ack");
    write_pair(8'h00, 8'h11, "R9");
    write_pair(8'h01, 8'h80, "R9");
    bus_stop();
    chk("R9 two pairs", {16'd0, codes}, 32'h0000_8011);
  endtask

  task automatic t_wrong_addr();
    logic a;
    open_addr(8'h5A, 1'b0, "R3 wrong strap no ack");
    send_byte(8'h00, a); chk("R11 cmd ignored", {31'd0, a}, 32'd0);
    send_byte(8'hFF, a); chk("R11 data ignored", {31'd0, a}, 32'd0);
    bus_stop();
    chk("R11 codes unchanged", {16'd0, codes}, 32'h0000_8011);
    open_addr(8'h5D, 1'b0, "R3 read flag no ack");
    send_byte(8'h01, a); chk("R11 cmd ignored after read", {31'd0, a}, 32'd0);
    bus_stop();
    open_addr(8'h7C, 1'b0, "R3 prefix mismatch no ack");
    bus_stop();
    chk("R11 codes unchanged 2", {16'd0, codes}, 32'h0000_8011);
  endtask

  task automatic t_dangling();
    logic a;
    open_addr(8'h5C, 1'b1, "R3 address ack");
    send_byte(8'h01, a); chk("R10 cmd ack", {31'd0, a}, 32'd1);
    bus_stop();
    chk("R10 dangling cmd no change", {16'd0, codes}, 32'h0000_8011);
    chk("R10 pull low after stop", {31'd0, sda_pull}, 32'd0);
  endtask

  task automatic t_restart();
    logic a;
    open_addr(8'h5C, 1'b1, "R3 address ack");
    send_byte(8'h00, a); chk("R2 cmd ack", {31'd0, a}, 32'd1);
    open_addr(8'h5C, 1'b1, "R2 repeated start address ack");
    write_pair(8'h01, 8'h77, "R2");
    bus_stop();
    chk("R2 restart write ch1 only", {16'd0, codes}, 32'h0000_7711);
  endtask

  task automatic t_new_strap();
    sel = 2'b01;
    open_addr(8'h5A, 1'b1, "R3 new strap ack");
    write_pair(8'h00, 8'h42, "R3");
    bus_stop();
    chk("R3 write via new strap", {16'd0, codes}, 32'h0000_7742);
    open_addr(8'h5C, 1'b0, "R3 old strap no ack");
    bus_stop();
  endtask

  task automatic t_clear();
    open_addr(8'h5A, 1'b1, "R3 address ack");
    write_pair(8'h08, 8'h55, "R7");
    bus_stop();
    chk("R7 clear all", {16'd0, codes}, 32'd0);
  endtask

  initial begin
    #(Q * 2);
    @(negedge clk) rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_write_ch0();
    t_other_bits();
    t_multi_pair();
    t_wrong_addr();
    t_dangling();
    t_restart();
    t_new_strap();
    t_clear();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4ns);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule